// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor with a 16-bit address space. It runs three kinds of machine cycle: opcode fetch, memory read and memory write. For each cycle it drives the address bus, five active-low strobes (first-cycle marker, memory request, read, write and refresh), and the output enable of the data bus. The data bus is split into an input byte, an output byte and an enable, and the pad ring joins them. The block keeps its own program counter, which supplies the fetch address. It also keeps a 7-bit refresh counter, which it puts on the low address lines during the second half of every fetch.

The block runs on a clock at twice the T-state rate. A phase bit inside it tells the two halves of each T-state apart, so strobes can change on half-T-state boundaries while every register stays on one clock edge. In this document, "half" means one period of that clock, and T-state k consists of its first half (p0) and its second half (p1). The requester presents a cycle kind, an address and a write byte while `reqReady` is high. When the cycle ends, the block pulses `done`, and `rdData` holds the byte it captured.

Top module: `busseq_top`

## Requirements
- R1: Out of reset, and in every half with no cycle running, all five strobes are high, `dataOe` is low, `done` is low and `reqReady` is high.
- R2: A fetch lasts four T-states (T1, T2, T3, T4) plus any wait states. The first-cycle strobe is low from T1 p0 until the end of the last wait state. Memory request and read are low from T1 p1 until the end of the last wait state. `done` is high only in T4 p1.
- R3: During T1, T2 and the wait states of a fetch, the address bus carries the program counter. The counter counts up by one per fetch, wraps at 16 bits and resets to zero.
- R4: A fetch captures `dataIn` at the end of the half just before T3. `rdData` holds that byte after the cycle ends.
- R5: During T3 and T4 of a fetch, the low 7 address bits carry the refresh counter and the upper 9 bits are zero. The refresh strobe is low for all four of those halves. Memory request is low again in T3 p1 and T4 p0 only.
- R6: The refresh counter starts at zero after reset. It counts up by one at the end of every fetch and wraps modulo 128.
- R7: `waitN` is sampled at the end of T2 p1 and at the end of each wait state's p1. Each low sample inserts one more wait T-state before T3, in all three cycle kinds.
- R8: A memory read lasts three T-states plus wait states, and it keeps the first-cycle strobe high. Memory request and read are low from T1 p1 through T3 p0. `dataIn` is captured at the end of T3 p0. The address bus carries `reqAddr`. `done` is high in T3 p1.
- R9: In a memory write, memory request goes low and `dataOe` goes high (with `dataOut` = `reqWrData`) from T1 p1. Write is low from T2 p1. Both strobes are released at T3 p1. `dataOe` drops one half later. `done` is high in T3 p1.
- R10: The read and write strobes are never low in the same half.
- R11: A request is taken in a half where `reqReady` is high. T1 p0 starts in the next half, and `reqReady` stays low until the cycle has ended.
- R12: Cycle kind encoding on `reqKind`: 0 = fetch, 1 = memory read, 2 = memory write. Code 3 is ignored: no cycle starts, `reqReady` stays high and all strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the T-state rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Cycle request |
| reqKind | input | 2 | Cycle kind (R12 encoding) |
| reqAddr | input | 16 | Address for memory read or write |
| reqWrData | input | 8 | Byte to write |
| reqReady | output | 1 | Sequencer idle, request may be taken |
| done | output | 1 | One-half pulse in the final half of a cycle |
| rdData | output | 8 | Byte captured by the latest fetch or read |
| waitN | input | 1 | Active-low wait request |
| addrBus | output | 16 | Address bus |
| dataIn | input | 8 | Data bus input byte |
| dataOut | output | 8 | Data bus output byte |
| dataOe | output | 1 | Data bus output enable |
| m1N | output | 1 | First-cycle (opcode fetch) strobe |
| mreqN | output | 1 | Memory request strobe |
| rdN | output | 1 | Read strobe |
| wrN | output | 1 | Write strobe |
| rfshN | output | 1 | Refresh strobe |

## Verification
A request is accepted on one edge, and half 0 (T1 p0) of the cycle starts right after it. The strobes are decoded directly from the state, so a strobe value belongs to the half in which the bench reads it. With n wait states, T3 starts at half 4+2n. The bench samples every half of every cycle in its middle, and compares that sample with a pattern built from the half index, the cycle kind and n. To check the capture point, the bench drives the memory byte onto `dataIn` only during the capture half (half 3+2n for a fetch, 4+2n for a read) and the inverted byte in every other half. The result is read in the idle half after `done`.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_NONE  = 2'd3
  } busKind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } tState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;   // latch the request, pick the PC for a fetch
    logic isFetch;   // the request being latched is a fetch
    logic capRead;   // capture the data input
    logic incRfsh;   // step the refresh counter
    logic selRfsh;   // drive the refresh address
  } dpCtl_t;

endpackage

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
(
  input  logic   clk2x,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic [1:0] reqKind,
  input  logic   waitN,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   done,
  output logic   m1N,
  output logic   mreqN,
  output logic   rdN,
  output logic   wrN,
  output logic   rfshN,
  output logic   dataOe
);

  tState_e  state;
  logic     phase;
  busKind_e kindQ;
  logic     accept;
  logic     isFetch;
  logic     isRead;
  logic     isWrite;
  logic     inT1, inT2, inTW, inT3, inT4;
  logic     early;
  logic     lastHalf;

  assign inT1 = (state == ST_T1);
  assign inT2 = (state == ST_T2);
  assign inTW = (state == ST_TW);
  assign inT3 = (state == ST_T3);
  assign inT4 = (state == ST_T4);

  assign isFetch = (kindQ == KIND_FETCH);
  assign isRead  = (kindQ == KIND_READ);
  assign isWrite = (kindQ == KIND_WRITE);

  assign accept   = (state == ST_IDLE) && reqValid && (reqKind != KIND_NONE);
  assign reqReady = (state == ST_IDLE);

  // T1 second half up to the end of the last wait state
  assign early = (inT1 && phase) || inT2 || inTW;

  assign lastHalf = phase && ((isFetch && inT4) || (!isFetch && inT3));
  assign done     = lastHalf;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= 1'b0;
      kindQ <= KIND_FETCH;
    end else if (state == ST_IDLE) begin
      phase <= 1'b0;
      if (accept) begin
        state <= ST_T1;
        kindQ <= busKind_e'(reqKind);
      end
    end else if (!phase) begin
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      unique case (state)
        ST_T1:        state <= ST_T2;
        ST_T2, ST_TW: state <= waitN ? ST_T3 : ST_TW;
        ST_T3:        state <= isFetch ? ST_T4 : ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  // strobe decode
  always_comb begin
    m1N    = 1'b1;
    mreqN  = 1'b1;
    rdN    = 1'b1;
    wrN    = 1'b1;
    rfshN  = 1'b1;
    dataOe = 1'b0;
    if (isFetch) begin
      m1N   = !(inT1 || inT2 || inTW);
      mreqN = !(early || (inT3 && phase) || (inT4 && !phase));
      rdN   = !early;
      rfshN = !(inT3 || inT4);
    end else if (isRead) begin
      mreqN = !(early || (inT3 && !phase));
      rdN   = !(early || (inT3 && !phase));
    end else if (isWrite) begin
      mreqN  = !(early || (inT3 && !phase));
      wrN    = !((inT2 && phase) || inTW || (inT3 && !phase));
      dataOe = early || inT3;
    end
  end

  always_comb begin
    ctl.loadReq = accept;
    ctl.isFetch = (reqKind == KIND_FETCH);
    ctl.capRead = isFetch ? ((inT2 || inTW) && phase && waitN)
                          : (isRead && inT3 && !phase);
    ctl.incRfsh = isFetch && lastHalf;
    ctl.selRfsh = isFetch && (inT3 || inT4);
  end

endmodule

// File: rtl/busseq_dp.sv
module busseq_dp
  import busseq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RFSH_W   = 7,
  parameter logic [ADDR_W-1:0] PC_RESET = '0
) (
  input  logic              clk2x,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = ADDR_W - RFSH_W;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] addrQ;
  logic [RFSH_W-1:0] rfshQ;
  logic [DATA_W-1:0] wrQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      pcQ   <= PC_RESET;
      addrQ <= '0;
      wrQ   <= '0;
    end else if (ctl.loadReq) begin
      wrQ <= reqWrData;
      if (ctl.isFetch) begin
        addrQ <= pcQ;
        pcQ   <= pcQ + 1'b1;
      end else begin
        addrQ <= reqAddr;
      end
    end
  end

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      rfshQ <= '0;
    end else if (ctl.incRfsh) begin
      rfshQ <= rfshQ + 1'b1;
    end
  end

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (ctl.capRead) begin
      rdQ <= dataIn;
    end
  end

  assign addrBus = ctl.selRfsh ? {{PAD_W{1'b0}}, rfshQ} : addrQ;
  assign dataOut = wrQ;
  assign rdData  = rdQ;

endmodule

// File: rtl/busseq_top.sv
module busseq_top
  import busseq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RFSH_W   = 7,
  parameter logic [ADDR_W-1:0] PC_RESET = '0
) (
  input  logic              clk2x,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  input  logic              waitN,
  output logic [ADDR_W-1:0] addrBus,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              m1N,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic              rfshN
);

  dpCtl_t ctl;

  busseq_ctrl u_ctrl (
    .clk2x    (clk2x),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .waitN    (waitN),
    .ctl      (ctl),
    .reqReady (reqReady),
    .done     (done),
    .m1N      (m1N),
    .mreqN    (mreqN),
    .rdN      (rdN),
    .wrN      (wrN),
    .rfshN    (rfshN),
    .dataOe   (dataOe)
  );

  busseq_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RFSH_W   (RFSH_W),
    .PC_RESET (PC_RESET)
  ) u_dp (
    .clk2x     (clk2x),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .dataIn    (dataIn),
    .addrBus   (addrBus),
    .dataOut   (dataOut),
    .rdData    (rdData)
  );

endmodule

// File: rtl/busseq_chk.sv
module busseq_chk (
  input logic clk2x,
  input logic rstN,
  input logic reqReady,
  input logic done,
  input logic m1N,
  input logic mreqN,
  input logic rdN,
  input logic wrN,
  input logic rfshN,
  input logic dataOe
);

  a_r10_rd_wr_excl: assert property (@(posedge clk2x) disable iff (!rstN)
    !(!rdN && !wrN));

  a_r1_idle_quiet: assert property (@(posedge clk2x) disable iff (!rstN)
    reqReady |-> (m1N && mreqN && rdN && wrN && rfshN && !dataOe && !done));

  a_r9_wr_with_mreq: assert property (@(posedge clk2x) disable iff (!rstN)
    !wrN |-> (!mreqN && dataOe));

  a_r5_rfsh_not_m1: assert property (@(posedge clk2x) disable iff (!rstN)
    !rfshN |-> (m1N && rdN));

  a_r11_done_then_idle: assert property (@(posedge clk2x) disable iff (!rstN)
    done |=> reqReady);

  a_r2_m1_leads_mreq: assert property (@(posedge clk2x) disable iff (!rstN)
    $fell(m1N) |-> mreqN);

endmodule

bind busseq_top busseq_chk u_chk (
  .clk2x    (clk2x),
  .rstN     (rstN),
  .reqReady (reqReady),
  .done     (done),
  .m1N      (m1N),
  .mreqN    (mreqN),
  .rdN      (rdN),
  .wrN      (wrN),
  .rfshN    (rfshN),
  .dataOe   (dataOe)
);

// File: tb/sim_busseq_top.sv
module sim_busseq_top;

  localparam int CLK_PERIOD = 10;

  logic        clk2x = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [15:0] reqAddr;
  logic [7:0]  reqWrData;
  logic        reqReady;
  logic        done;
  logic [7:0]  rdData;
  logic        waitN;
  logic [15:0] addrBus;
  logic [7:0]  dataIn;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        m1N, mreqN, rdN, wrN, rfshN;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [15:0] pcM = 16'h0000;
  int rfM = 0;

  busseq_top u0 (
    .clk2x(clk2x), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqReady(reqReady),
    .done(done), .rdData(rdData), .waitN(waitN), .addrBus(addrBus),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .m1N(m1N),
    .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .rfshN(rfshN)
  );

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  always @(posedge clk2x) begin
    cycles++;
    if (cycles > 200000) begin
      miscompares++;
      $display("FAIL watchdog expired act=%0d exp=<200000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {m1N,mreqN,rdN,wrN,rfshN,dataOe,done,reqReady}
  function automatic logic [7:0] idleVec();
    return 8'b1111_1001;
  endfunction

  task automatic checkIdle(input string tag);
    logic [7:0] got;
    got = {m1N, mreqN, rdN, wrN, rfshN, dataOe, done, reqReady};
    chk(got == idleVec(), tag, {24'd0, got}, {24'd0, idleVec()});
  endtask

  task automatic runCycle(input int kind, input int n, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] md);
    int b, last, capH;
    logic [15:0] expA;
    @(posedge clk2x); #1;
    chk(reqReady == 1'b1, "R11 ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqKind = kind[1:0]; reqAddr = a; reqWrData = wd;
    expA = (kind == 0) ? pcM : a;
    if (kind == 0) pcM = pcM + 16'd1;
    b = 4 + 2*n;
    last = (kind == 0) ? b + 3 : b + 1;
    capH = (kind == 0) ? b - 1 : b;
    @(posedge clk2x); #1;
    reqValid = 1'b0;
    for (int h = 0; h <= last; h++) begin
      logic m1e, mre, rde, wre, rfe, oee, dne;
      logic [7:0] got, exp;
      logic [15:0] ea;
      if (h > 0) begin @(posedge clk2x); #1; end
      waitN  = !(h >= 2 && h < 2 + 2*n);
      dataIn = (h == capH) ? md : ~md;
      @(negedge clk2x);
      m1e = 1; mre = 1; rde = 1; wre = 1; rfe = 1; oee = 0;
      dne = (h == last);
      ea = expA;
      if (kind == 0) begin
        m1e = !(h < b);
        mre = !((h >= 1 && h < b) || h == b + 1 || h == b + 2);
        rde = !(h >= 1 && h < b);
        rfe = !(h >= b);
        if (h >= b) ea = {9'd0, rfM[6:0]};
      end else if (kind == 1) begin
        mre = !(h >= 1 && h <= b);
        rde = !(h >= 1 && h <= b);
      end else begin
        mre = !(h >= 1 && h <= b);
        wre = !(h >= 3 && h <= b);
        oee = (h >= 1 && h <= b + 1);
      end
      got = {m1N, mreqN, rdN, wrN, rfshN, dataOe, done, reqReady};
      exp = {m1e, mre, rde, wre, rfe, oee, dne, 1'b0};
      if (kind == 0)
        chk(got == exp, "R2 R5 R7 R11 fetch strobes", {24'd0, got}, {24'd0, exp});
      else if (kind == 1)
        chk(got == exp, "R8 R7 R11 read strobes", {24'd0, got}, {24'd0, exp});
      else
        chk(got == exp, "R9 R7 R11 write strobes", {24'd0, got}, {24'd0, exp});
      chk(addrBus == ea, (kind == 0) ? "R3 R5 R6 fetch address" : "R8 R9 address",
          {16'd0, addrBus}, {16'd0, ea});
      if (oee)
        chk(dataOut == wd, "R9 write data", {24'd0, dataOut}, {24'd0, wd});
    end
    waitN = 1'b1;
    @(posedge clk2x); #1;
    @(negedge clk2x);
    checkIdle("R1 R9 idle after cycle");
    if (kind == 0)
      chk(rdData == md, "R4 fetch capture", {24'd0, rdData}, {24'd0, md});
    else if (kind == 1)
      chk(rdData == md, "R8 read capture", {24'd0, rdData}, {24'd0, md});
    if (kind == 0) rfM = (rfM + 1) % 128;
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqAddr = '0;
    reqWrData = '0; waitN = 1'b1; dataIn = '0;
    repeat (3) @(posedge clk2x);
    #1 rstN = 1'b1;
    @(negedge clk2x);
    checkIdle("R1 reset state");
    chk(addrBus == 16'h0000, "R1 R3 reset address", {16'd0, addrBus}, 32'd0);

    // R12: code 3 starts nothing
    @(posedge clk2x); #1;
    reqValid = 1'b1; reqKind = 2'd3; reqAddr = 16'hBEEF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk2x);
      checkIdle("R12 ignored kind");
      @(posedge clk2x); #1;
    end
    reqValid = 1'b0;

    // sweep of kinds, wait counts and data patterns (R2 R7 R8 R9)
    for (int k = 0; k < 3; k++)
      for (int n = 0; n < 4; n++)
        for (int d = 0; d < 4; d++)
          runCycle(k, n, 16'h1234 + 16'(k*4099 + n*257 + d*31),
                   8'(8'h5A ^ (d*37 + n)), 8'(8'hC3 + d*71 + k*5));

    // R6: refresh counter wraps past 127
    for (int i = 0; i < 130; i++)
      runCycle(0, 0, 16'h0000, 8'h00, 8'(i * 13));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule